// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of an I/O controller. A host reaches it through two byte addresses on a simple I/O bus: an index address at the base and a data address at base plus one. The port starts out closed. It opens only after a fixed key byte has been written twice in a row to the index address, and it closes again on a separate lock byte. While it is open, a byte written to the index address picks a configuration register, and reads or writes at the data address reach that register.

The global registers are a logical device select, a 16-bit device ID, a revision byte and a 16-bit manufacturer ID. The device ID and revision are build parameters. Register numbers from 0x30 upward are banked: they reach the logical device named by the select register. Only the general-purpose I/O device (number 0x06) is present, as a small register file. Every other device, and every unimplemented register, reads as 0xFF and ignores writes.

Top module: `cfgport`

## Requirements
- R1: After reset the port is closed (`cfg_open` = 0), the index register holds 0x00 and the logical device select holds 0x00.
- R2: The port opens only after 0x87 has been written twice in a row to the index address (`io_addr` = BASE). `cfg_open` rises in the cycle after the second key write.
- R3: If the first 0x87 is followed by any other write to either port address (another value at the index address, or any write at the data address), the port stays closed and the key sequence starts over.
- R4: Writing 0xAA to the index address while open closes the port and leaves the index unchanged. While closed, data-address writes change nothing, and data-address reads return 0xFF.
- R5: While the port is closed, writes to the index address other than the key do not change the index register.
- R6: The data register sits at BASE+1. Reads at any address other than BASE or BASE+1 produce no `io_rvalid`. While open, a read at BASE returns the current index.
- R7: Register 0x20 returns the device ID high byte, 0x21 the low byte, and 0x22 the revision.
- R8: Register 0x23 returns 0x19 and register 0x24 returns 0x34, the two bytes of manufacturer ID 0x1934, high byte first.
- R9: Register 0x07 is the readable and writable logical device select. With device 0x06 selected, registers 0x30 through 0x30+GPIO_REGS-1 store and return bytes written through the data address.
- R10: Reads of unimplemented global registers, of banked registers when any device other than 0x06 is selected, and of banked registers past the end of the device 0x06 file return 0xFF. Writes to these registers have no effect.
- R11: A read at BASE or BASE+1 returns its byte on `io_rdata`, with `io_rvalid` high, in the cycle after the read strobe. Back-to-back reads are allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O bus byte address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid when io_rvalid is high |
| io_rvalid | output | 1 | Read data valid, one cycle after a decoded read |
| cfg_open | output | 1 | Port is open for configuration access |

## Verification
Writes take effect at the clock edge that samples the strobe. `cfg_open` is therefore checked just after the edge that follows a key or lock write. Every decoded read returns data exactly one cycle after its strobe. The read task pushes the expected byte into a queue right after the strobe edge. The monitor then runs at the following falling edge and requires `io_rvalid` together with a matching byte whenever the queue holds an entry. A late, early or stray `io_rvalid` is therefore reported, and so is a wrong byte.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_state_e;

  localparam logic [7:0] KEY_ON     = 8'h87;
  localparam logic [7:0] KEY_OFF    = 8'hAA;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;

  localparam logic [7:0] R_LDSEL    = 8'h07;
  localparam logic [7:0] R_DEVID_HI = 8'h20;
  localparam logic [7:0] R_DEVID_LO = 8'h21;
  localparam logic [7:0] R_REV      = 8'h22;
  localparam logic [7:0] R_VEND_HI  = 8'h23;
  localparam logic [7:0] R_VEND_LO  = 8'h24;
  localparam logic [7:0] R_LD_FIRST = 8'h30;

  localparam logic [15:0] VENDOR_ID = 16'h1934;
  localparam logic [7:0]  LD_GPIO   = 8'h06;
endpackage

// File: rtl/cfgport_key.sv
module cfgport_key
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic       port_wr,
  input  logic [7:0] wdata,
  output logic       open
);
  key_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KS_LOCKED;
    end else if (port_wr) begin
      case (state_q)
        KS_LOCKED: if (idx_wr && wdata == KEY_ON) state_q <= KS_HALF;
        KS_HALF:   state_q <= (idx_wr && wdata == KEY_ON) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   if (idx_wr && wdata == KEY_OFF) state_q <= KS_LOCKED;
        default:   state_q <= KS_LOCKED;
      endcase
    end
  end

  assign open = (state_q == KS_OPEN);

  // R2: opening is always preceded by a key write on the index address
  assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(open) |-> $past(idx_wr && wdata == KEY_ON));

  // R3: a non-key write while closed never opens the port
  assert_break_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (!open && port_wr && !(idx_wr && wdata == KEY_ON)) |=> !open);

  // R4: lock byte closes the port
  assert_lock_closes_R4: assert property (@(posedge clk) disable iff (rst)
    (open && idx_wr && wdata == KEY_OFF) |=> !open);
endmodule

// File: rtl/cfgport_ldstub.sv
module cfgport_ldstub #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       we,
  input  logic       re,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;
  logic [AW-1:0] waddr;

  assign waddr = addr[AW-1:0];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[waddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cfgport.sv
module cfgport
  import cfgport_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE      = 'h2E,
  parameter logic [15:0]       DEV_ID    = 16'h0A51,
  parameter logic [7:0]        DEV_REV   = 8'h03,
  parameter int                GPIO_REGS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              cfg_open
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE + 1'b1;
  localparam int LD_END = 'h30 + GPIO_REGS;

  logic       idx_hit, dat_hit;
  logic [7:0] idx_q, ldsel_q, glob_val, glob_q;
  logic       stub_sel_q, rvalid_q, stub_hit, stub_acc_ok;
  logic [7:0] stub_off, stub_rdata;

  assign idx_hit = (io_addr == BASE);
  assign dat_hit = (io_addr == DAT_ADDR);

  cfgport_key u_key (
    .clk     (clk),
    .rst     (rst),
    .idx_wr  (io_wr && idx_hit),
    .port_wr (io_wr && (idx_hit || dat_hit)),
    .wdata   (io_wdata),
    .open    (cfg_open)
  );

  assign stub_hit    = (ldsel_q == LD_GPIO) && (idx_q >= R_LD_FIRST) && (int'(idx_q) < LD_END);
  assign stub_acc_ok = dat_hit && cfg_open && stub_hit;
  assign stub_off    = idx_q - R_LD_FIRST;

  cfgport_ldstub #(.DEPTH(GPIO_REGS)) u_gpio (
    .clk   (clk),
    .we    (io_wr && stub_acc_ok),
    .re    (io_rd && stub_acc_ok),
    .addr  (stub_off),
    .wdata (io_wdata),
    .rdata (stub_rdata)
  );

  always_comb begin
    glob_val = IDLE_BYTE;
    if (cfg_open) begin
      if (idx_hit) begin
        glob_val = idx_q;
      end else begin
        case (idx_q)
          R_LDSEL:    glob_val = ldsel_q;
          R_DEVID_HI: glob_val = DEV_ID[15:8];
          R_DEVID_LO: glob_val = DEV_ID[7:0];
          R_REV:      glob_val = DEV_REV;
          R_VEND_HI:  glob_val = VENDOR_ID[15:8];
          R_VEND_LO:  glob_val = VENDOR_ID[7:0];
          default:    glob_val = IDLE_BYTE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= 8'h00;
      ldsel_q    <= 8'h00;
      glob_q     <= IDLE_BYTE;
      stub_sel_q <= 1'b0;
      rvalid_q   <= 1'b0;
    end else begin
      rvalid_q <= io_rd && (idx_hit || dat_hit);
      if (io_rd) begin
        glob_q     <= glob_val;
        stub_sel_q <= stub_acc_ok;
      end
      if (io_wr && cfg_open) begin
        if (idx_hit && io_wdata != KEY_OFF) idx_q <= io_wdata;
        if (dat_hit && idx_q == R_LDSEL)   ldsel_q <= io_wdata;
      end
    end
  end

  assign io_rdata  = stub_sel_q ? stub_rdata : glob_q;
  assign io_rvalid = rvalid_q;

  // R5: index register holds while the port is closed
  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(idx_q));

  // R4: device select holds while the port is closed
  assert_ldsel_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(ldsel_q));

  // R4: closed data reads return the idle byte
  assert_closed_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && dat_hit && !cfg_open) |=> (io_rvalid && io_rdata == IDLE_BYTE));

  // R11: decoded read answers one cycle later
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (io_rd && (idx_hit || dat_hit)) |=> io_rvalid);

  // R6: undecoded read gives no valid
  assert_no_stray_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (!io_rd || !(idx_hit || dat_hit)) |=> !io_rvalid);
endmodule

// File: tb/test_cfgport.sv
module test_cfgport;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] IDX = 16'h002E;
  localparam logic [ADDR_W-1:0] DAT = 16'h002F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic io_rvalid, cfg_open;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  cfgport #(.ADDR_W(ADDR_W), .BASE(IDX), .DEV_ID(16'h0A51), .DEV_REV(8'h03), .GPIO_REGS(16)) i_cfgport (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid), .cfg_open(cfg_open)
  );

  // monitor: one-cycle latency, compared at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (!io_rvalid) begin
          bad++;
          $display("FAIL %s: rvalid=0 expected 1 (data exp %02h)", t, e);
        end else if (io_rdata !== e) begin
          bad++;
          $display("FAIL %s: rdata=%02h expected %02h", t, io_rdata, e);
        end
      end else if (io_rvalid) begin
        total++;
        bad++;
        $display("FAIL R11: stray rvalid=1 expected 0");
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic chk_open(input logic e, input string t);
    total++;
    if (cfg_open !== e) begin
      bad++;
      $display("FAIL %s: cfg_open=%0b expected %0b", t, cfg_open, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk_open(1'b0, "R1 reset closed");
    rd(DAT, 8'hFF, "R4 closed data read");
    rd(DAT, 8'hFF, "R11 back-to-back closed read");
    wr(IDX, 8'h22);              // closed index write, ignored (R5)
    wr(DAT, 8'h55);              // closed data write, ignored (R4)
    // R3: broken key sequences
    wr(IDX, 8'h87); wr(IDX, 8'h11);
    wr(IDX, 8'h87);
    chk_open(1'b0, "R3 single key");
    wr(DAT, 8'h00);
    wr(IDX, 8'h87);
    chk_open(1'b0, "R3 data write between keys");
    wr(IDX, 8'h87);
    chk_open(1'b1, "R2 double key opens");
    rd(IDX, 8'h00, "R5 R1 index unchanged by closed writes");
    wr(IDX, 8'h07);
    rd(DAT, 8'h00, "R1 device select reset value");
    // R7 R8 ID readback
    wr(IDX, 8'h20); rd(DAT, 8'h0A, "R7 device id high");
    wr(IDX, 8'h21); rd(DAT, 8'h51, "R7 device id low");
    wr(IDX, 8'h22); rd(DAT, 8'h03, "R7 revision");
    wr(IDX, 8'h23); rd(DAT, 8'h19, "R8 vendor high");
    wr(IDX, 8'h24); rd(DAT, 8'h34, "R8 vendor low");
    // R10 unimplemented global
    wr(IDX, 8'h10); wr(DAT, 8'h42); rd(DAT, 8'hFF, "R10 unimplemented global");
    // R9 banked gpio file
    wr(IDX, 8'h07); wr(DAT, 8'h06); rd(DAT, 8'h06, "R9 select readback");
    wr(IDX, 8'h30); wr(DAT, 8'h5A);
    wr(IDX, 8'h3F); wr(DAT, 8'hA5);
    wr(IDX, 8'h30); rd(DAT, 8'h5A, "R9 first gpio reg");
    wr(IDX, 8'h3F); rd(DAT, 8'hA5, "R9 last gpio reg");
    wr(IDX, 8'h40); wr(DAT, 8'h99); rd(DAT, 8'hFF, "R10 past gpio file");
    // R10 other device
    wr(IDX, 8'h07); wr(DAT, 8'h05);
    wr(IDX, 8'h30); rd(DAT, 8'hFF, "R10 other device read");
    wr(DAT, 8'h77);
    wr(IDX, 8'h07); wr(DAT, 8'h06);
    wr(IDX, 8'h30); rd(DAT, 8'h5A, "R10 other device write ignored");
    // R6 undecoded address
    io_addr = IDX + 16'd2; io_rd = 1'b1;
    @(posedge clk); #1; io_rd = 1'b0;
    total++;
    if (io_rvalid !== 1'b0) begin
      bad++;
      $display("FAIL R6: rvalid=%0b expected 0", io_rvalid);
    end
    // R4 lock then no effect
    wr(IDX, 8'hAA);
    chk_open(1'b0, "R4 lock closes");
    wr(DAT, 8'h00);
    rd(DAT, 8'hFF, "R4 closed after lock");
    wr(IDX, 8'h87); wr(IDX, 8'h87);
    chk_open(1'b1, "R2 reopen");
    rd(IDX, 8'h30, "R4 lock keeps index");
    rd(DAT, 8'h5A, "R4 closed write had no effect");
    idle(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule